// File: doc/BRIEF.md
# Fetch Address Unit with Return Stack

This block produces the instruction fetch address for a small 8-bit controller core. It keeps a 13-bit logical program counter covering an 8K-word space, while only a 2K-word program store is physically present. The physical address handed to that store is the low 11 bits of the logical counter, so any logical address above 07FFh lands back inside the implemented words. A private 8-entry return stack, reachable only through call, return and interrupt actions, holds return addresses.

Instruction decode drives a set of plain strobes: an instruction-cycle enable, an interrupt-accept strobe, and jump, call and return requests with a shared 13-bit target. The block acts only in cycles where the enable is high. In such a cycle exactly one action takes place, chosen by fixed priority: interrupt, then return, then call, then jump, then a plain step to the next word. A call pushes the address after itself. An accepted interrupt pushes the address it pre-empted and enters the vector at 0004h. A return pops. The stack is circular and raises no flags on overflow or underflow. There is no stream data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `fetch_addr_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) loads the counter with 0000h, sets the stack pointer to zero and clears every stack entry, whatever the other inputs are doing, so a return issued straight after reset yields 0000h.
- R2: In an enabled cycle with no strobe, the counter advances by one modulo 8192, so 1FFFh is followed by 0000h.
- R3: While cyc_en is low, the counter and the stack hold their state and all strobes are ignored.
- R4: An enabled jump with no higher-priority strobe loads the counter with target and leaves the stack unchanged.
- R5: An enabled call with no higher-priority strobe pushes the counter value plus one (modulo 8192) and loads the counter with target.
- R6: An enabled return with no interrupt pops the stack into the counter, giving the most recent value pushed and not yet popped.
- R7: An enabled interrupt accept pushes the current counter value unchanged and loads 0004h, overriding any return, call or jump in the same cycle.
- R8: When several of return, call and jump are high in one enabled cycle, return acts alone if present, and otherwise call acts alone.
- R9: The stack is an 8-entry ring: a ninth push overwrites the oldest entry, and after nine pushes the next eight pops give pushes nine down to two, and a further pop gives push nine again.
- R10: pmem_addr always equals pc[10:0], following pc in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_en | input | 1 | Instruction-cycle enable; the block updates only when high |
| irq_take | input | 1 | Interrupt accepted this cycle |
| jump_req | input | 1 | Absolute jump to target |
| call_req | input | 1 | Call to target, pushing the next address |
| ret_req | input | 1 | Return: pop into the counter |
| target | input | 13 | Jump and call destination |
| pc | output | 13 | Logical program counter |
| pmem_addr | output | 11 | Physical program-store address |

## Verification
The hardest state to reach from the ports is a full ring that has wrapped: an overwritten oldest entry only shows itself after nine nested calls and then eight returns. The bench drives that run directly and issues one return more to confirm that the pointer wraps and no data comes from an empty slot. It also drives reset in the same cycle as an interrupt and a call, then issues a return to show that the stack was cleared. Weighted random strobes mixing all priorities then exercise the stack at many depths, including pops beyond empty.

// File: rtl/fau_pkg.sv
package fau_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_STEP,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_IRQ
  } fau_op_e;
endpackage

// File: rtl/fau_sel.sv
module fau_sel
  import fau_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int IRQ_VEC = 4
) (
  input  logic            cyc_en,
  input  logic            irq_take,
  input  logic            jump_req,
  input  logic            call_req,
  input  logic            ret_req,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] pop_data,
  output fau_op_e         op,
  output logic [PC_W-1:0] next_pc,
  output logic            push,
  output logic            pop,
  output logic [PC_W-1:0] push_data
);
  logic [PC_W-1:0] pc_inc;
  assign pc_inc = pc + PC_W'(1);

  // fixed priority: interrupt, return, call, jump, step
  always_comb begin
    if (!cyc_en)       op = OP_HOLD;
    else if (irq_take) op = OP_IRQ;
    else if (ret_req)  op = OP_RET;
    else if (call_req) op = OP_CALL;
    else if (jump_req) op = OP_JUMP;
    else               op = OP_STEP;
  end

  always_comb begin
    next_pc   = pc;
    push      = 1'b0;
    pop       = 1'b0;
    push_data = '0;
    unique case (op)
      OP_IRQ: begin
        push      = 1'b1;
        push_data = pc;
        next_pc   = PC_W'(IRQ_VEC);
      end
      OP_RET: begin
        pop     = 1'b1;
        next_pc = pop_data;
      end
      OP_CALL: begin
        push      = 1'b1;
        push_data = pc_inc;
        next_pc   = target;
      end
      OP_JUMP: next_pc = target;
      OP_STEP: next_pc = pc_inc;
      default: next_pc = pc;
    endcase
  end
endmodule

// File: rtl/fau_ret_stack.sv
module fau_ret_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] pop_data
);
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0]    sp;
  logic [SP_W-1:0]    rd_idx;
  logic [DEPTH*W-1:0] ent_flat;

  assign rd_idx = sp - SP_W'(1);

  // ring pointer: wraps silently in both directions
  always_ff @(posedge clk) begin
    if (!rst_n)    sp <= '0;
    else if (push) sp <= sp + SP_W'(1);
    else if (pop)  sp <= sp - SP_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           q <= '0;
      else if (push && (sp == SP_W'(g)))    q <= push_data;
    end
    assign ent_flat[g*W +: W] = q;
  end

  assign pop_data = ent_flat[rd_idx*W +: W];

  // the selector must never request both stack actions at once
  always_ff @(posedge clk) begin
    if (rst_n) begin
      assert_one_stack_op_R8: assert (!(push && pop))
        else $error("push and pop requested together");
    end
  end
endmodule

// File: rtl/fau_addr_fold.sv
module fau_addr_fold #(
  parameter int PC_W   = 13,
  parameter int PHYS_W = 11
) (
  input  logic [PC_W-1:0]   pc,
  output logic [PHYS_W-1:0] addr
);
  if (PHYS_W < PC_W) begin : g_fold
    assign addr = pc[PHYS_W-1:0];
  end else if (PHYS_W == PC_W) begin : g_same
    assign addr = pc;
  end else begin : g_wide
    assign addr = {{(PHYS_W-PC_W){1'b0}}, pc};
  end

  always_comb begin
    if (!$isunknown(pc)) begin
      assert_fold_R10: assert (32'(addr) == (32'(pc) % (32'd1 << PHYS_W)))
        else $error("physical address is not the folded counter");
    end
  end
endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit
  import fau_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int PHYS_W    = 11,
  parameter int DEPTH     = 8,
  parameter int RESET_VEC = 0,
  parameter int IRQ_VEC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              irq_take,
  input  logic              jump_req,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   pc,
  output logic [PHYS_W-1:0] pmem_addr
);
  fau_op_e         op;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] next_pc;
  logic [PC_W-1:0] push_data;
  logic [PC_W-1:0] pop_data;
  logic            push;
  logic            pop;

  fau_sel #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) sel_i (
    .cyc_en    (cyc_en),
    .irq_take  (irq_take),
    .jump_req  (jump_req),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .target    (target),
    .pc        (pc_q),
    .pop_data  (pop_data),
    .op        (op),
    .next_pc   (next_pc),
    .push      (push),
    .pop       (pop),
    .push_data (push_data)
  );

  fau_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) stack_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_data (push_data),
    .pop_data  (pop_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= PC_W'(RESET_VEC);
    else        pc_q <= next_pc;
  end

  assign pc = pc_q;

  fau_addr_fold #(.PC_W(PC_W), .PHYS_W(PHYS_W)) fold_i (
    .pc   (pc_q),
    .addr (pmem_addr)
  );

  // tracker for the push-then-pop check
  logic            pushed_q;
  logic [PC_W-1:0] pushed_val_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pushed_q     <= 1'b0;
      pushed_val_q <= '0;
    end else begin
      pushed_q     <= push;
      pushed_val_q <= push_data;
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> (pc == $past(pc) + PC_W'(1)))
    else $error("step did not advance by one");

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(pc))
    else $error("counter moved while idle");

  assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JUMP) |=> (pc == $past(target)))
    else $error("jump did not load target");

  assert_call_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !irq_take && !ret_req && call_req) |=> (pc == $past(target)))
    else $error("call did not load target");

  assert_pop_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pushed_q && op == OP_RET) |=> (pc == $past(pushed_val_q)))
    else $error("return did not give the last pushed value");

  assert_irq_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && irq_take) |=> (pc == PC_W'(IRQ_VEC)))
    else $error("interrupt did not enter its vector");
endmodule

// File: tb/fetch_addr_unit_tb_top.sv
`timescale 1ns/1ps
module fetch_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_en = 1'b0;
  logic        irq_take = 1'b0;
  logic        jump_req = 1'b0;
  logic        call_req = 1'b0;
  logic        ret_req = 1'b0;
  logic [12:0] target = '0;
  logic [12:0] pc;
  logic [10:0] pmem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [12:0] m_pc;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp;

  always #2 clk = ~clk;

  fetch_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .irq_take(irq_take),
    .jump_req(jump_req), .call_req(call_req), .ret_req(ret_req),
    .target(target), .pc(pc), .pmem_addr(pmem_addr)
  );

  function automatic logic [10:0] fold(input logic [12:0] v);
    return v[10:0];
  endfunction

  function automatic string op_tag(input bit c, input bit i, input bit r,
                                   input bit ca, input bit j);
    if (!c) return "R3";
    if (i)  return "R7";
    if (r)  return "R6";
    if (ca) return "R5";
    if (j)  return "R4";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit c, input bit i, input bit r, input bit ca,
                            input bit j, input logic [12:0] t);
    if (!c) return;
    if (i) begin
      m_stk[m_sp] = m_pc; m_sp = m_sp + 3'd1; m_pc = 13'h0004;
    end else if (r) begin
      m_sp = m_sp - 3'd1; m_pc = m_stk[m_sp];
    end else if (ca) begin
      m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 3'd1; m_pc = t;
    end else if (j) begin
      m_pc = t;
    end else begin
      m_pc = m_pc + 13'd1;
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic cyc(input bit c, input bit i, input bit r, input bit ca,
                     input bit j, input logic [12:0] t, input string tag);
    cyc_en = c; irq_take = i; ret_req = r; call_req = ca; jump_req = j; target = t;
    @(posedge clk);
    model_step(c, i, r, ca, j, t);
    @(negedge clk);
    check(tag, pc, m_pc);
    check("R10", {2'b00, pmem_addr}, {2'b00, fold(m_pc)});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc_en = 1'b1; irq_take = 1'b1; call_req = 1'b1; target = 13'h0abc;
    @(posedge clk);
    m_pc = 13'h0000; m_sp = 3'd0;
    for (int k = 0; k < 8; k++) m_stk[k] = 13'h0000;
    @(negedge clk);
    check("R1", pc, 13'h0000);
    rst_n = 1'b1; cyc_en = 1'b0; irq_take = 1'b0; call_req = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    // R1: pop straight after reset gives a cleared entry
    cyc(1, 0, 1, 0, 0, 13'h0, "R1");
    do_reset();
    // R2: plain steps and wrap at the top of the space
    repeat (3) cyc(1, 0, 0, 0, 0, 13'h0, "R2");
    cyc(1, 0, 0, 0, 1, 13'h1ffe, "R4");
    cyc(1, 0, 0, 0, 0, 13'h0, "R2");
    cyc(1, 0, 0, 0, 0, 13'h0, "R2");
    check("R2", pc, 13'h0000);
    // R10: high logical address folds
    cyc(1, 0, 0, 0, 1, 13'h1abc, "R10");
    check("R10", {2'b00, pmem_addr}, 13'h02bc);
    // R5 / R6: call then return
    cyc(1, 0, 0, 0, 1, 13'h0100, "R4");
    cyc(1, 0, 0, 1, 0, 13'h0800, "R5");
    // R3: idle cycles with every strobe high change nothing
    cyc(0, 1, 1, 1, 1, 13'h0123, "R3");
    cyc(0, 0, 1, 0, 0, 13'h0000, "R3");
    cyc(1, 0, 1, 0, 0, 13'h0, "R6");
    check("R6", pc, 13'h0101);
    // R7: interrupt overrides everything, pushes unchanged counter
    cyc(1, 1, 1, 1, 1, 13'h0555, "R7");
    check("R7", pc, 13'h0004);
    cyc(1, 0, 1, 0, 0, 13'h0, "R7");
    check("R7", pc, 13'h0101);
    // R8: return beats call and jump, call beats jump
    cyc(1, 0, 0, 1, 1, 13'h0200, "R8");
    cyc(1, 0, 0, 1, 1, 13'h0300, "R8");
    cyc(1, 0, 1, 1, 1, 13'h0400, "R8");
    check("R8", pc, 13'h0201);
    cyc(1, 0, 1, 0, 0, 13'h0, "R8");
    check("R8", pc, 13'h0102);
    // R9: ring overflow and wrap
    do_reset();
    for (int k = 1; k <= 9; k++) cyc(1, 0, 0, 1, 0, 13'(k * 16), "R9");
    for (int k = 9; k >= 2; k--) begin
      cyc(1, 0, 1, 0, 0, 13'h0, "R9");
      check("R9", pc, 13'((k - 1) * 16 + 1));
    end
    cyc(1, 0, 1, 0, 0, 13'h0, "R9");
    check("R9", pc, 13'h0081);
    // weighted random mix
    for (int n = 0; n < 3000; n++) begin
      bit c, i, r, ca, j;
      logic [12:0] t;
      c  = ($urandom_range(0, 9) != 0);
      i  = ($urandom_range(0, 15) == 0);
      r  = ($urandom_range(0, 4) == 0);
      ca = ($urandom_range(0, 4) == 0);
      j  = ($urandom_range(0, 5) == 0);
      t  = 13'($urandom);
      if ($urandom_range(0, 7) == 0) t = 13'h1fff;
      cyc(c, i, r, ca, j, t, op_tag(c, i, r, ca, j));
      if (n == 1500) do_reset();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule